// File: doc/BRIEF.md
# Remainder-Aware Work Partition Generator

The block splits a work length across a number of partitions and streams out, one partition per handshake, the share each partition receives and where that share starts. A command carries the length L and the partition count N over a ready/valid input. The block divides L by N with a serial restoring divider. It then emits N tuples of (index, count, offset). The lowest-indexed partitions each take one extra unit until the remainder is used up.

In a compute array one instance splits the inner-dimension length across rows, and a second instance splits the output-column length across columns. That length is a count of native vectors, not a number of physical columns. A partition count of zero is refused: the block pulses an error flag and emits no tuples.

Top module: `wpart_gen`

## Requirements
- R1: After reset `cmd_ready` is 1, `out_valid` is 0 and `cmd_err` is 0.
- R2: A command with N between 1 and MAX_PARTS produces exactly N output tuples, with indices 0 to N-1 in increasing order.
- R3: The tuple for index i carries count floor(L/N)+1 when i < (L mod N), and floor(L/N) otherwise.
- R4: The tuple for index i carries offset equal to the sum of the counts of indices 0 to i-1. The offset of index 0 is 0.
- R5: `out_last` is 1 exactly on the tuple with index N-1.
- R6: When L < N, the tuples at index L and above are still emitted, each with count 0.
- R7: A command with N = 0 raises `cmd_err` for exactly one cycle, one cycle after it is accepted. No tuple is produced for it, and `cmd_ready` returns to 1.
- R8: `cmd_ready` stays 0 from the acceptance of a command until the last tuple has been taken. An output tuple is held stable while `out_valid` is 1 and `out_ready` is 0.
- R9: The first tuple appears LEN_W+2 cycles after the command is accepted: one cycle to load, LEN_W cycles of division, and one cycle to present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can take a command |
| cmd_len | input | LEN_W | Work length L |
| cmd_parts | input | PART_W | Partition count N |
| cmd_err | output | 1 | One-cycle pulse for a rejected N = 0 command |
| out_valid | output | 1 | Tuple present |
| out_ready | input | 1 | Consumer takes the tuple |
| out_index | output | PART_W | Partition index |
| out_count | output | LEN_W | Units given to this partition |
| out_offset | output | LEN_W | Start offset of this partition |
| out_last | output | 1 | Final partition of the command |

## Verification
A small configuration (LEN_W=6, MAX_PARTS=5) is swept over every length and every partition count, including zero. The zero-remainder cases show whether the extra unit is placed only when it is due. Lengths below the partition count show that zero-count tail partitions are still emitted. The N=1 and N=MAX_PARTS cases test the last flag at both ends of the index range.

A pseudo-random stall pattern on `out_ready` shows whether tuples hold steady under back-pressure. The same pattern shows whether a new command is locked out until the stream drains. The cycle count from command acceptance to the first tuple is measured once, to check the divider latency.

// File: rtl/wpart_pkg.sv
package wpart_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DIV  = 2'd1,
    ST_EMIT = 2'd2,
    ST_ERR  = 2'd3
  } wp_state_e;
endpackage

// File: rtl/wpart_div.sv
module wpart_div #(
  parameter int LEN_W  = 16,
  parameter int PART_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  dividend,
  input  logic [PART_W-1:0] divisor,
  output logic              done,
  output logic [LEN_W-1:0]  quot,
  output logic [PART_W-1:0] rem
);
  localparam int CNT_W = $clog2(LEN_W + 1);
  localparam int REM_W = PART_W + 1;

  logic [LEN_W-1:0]  q_q, q_d;
  logic [REM_W-1:0]  r_q, r_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              busy_q, busy_d;
  logic              done_q, done_d;
  logic [PART_W-1:0] dvs_q, dvs_d;
  logic [REM_W-1:0]  trial;

  always_comb begin
    q_d    = q_q;
    r_d    = r_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    done_d = 1'b0;
    dvs_d  = dvs_q;
    trial  = {r_q[PART_W-1:0], q_q[LEN_W-1]};
    if (start) begin
      q_d    = dividend;
      r_d    = '0;
      dvs_d  = divisor;
      cnt_d  = CNT_W'(LEN_W);
      busy_d = 1'b1;
    end else if (busy_q) begin
      if (trial >= {1'b0, dvs_q}) begin
        r_d = trial - {1'b0, dvs_q};
        q_d = {q_q[LEN_W-2:0], 1'b1};
      end else begin
        r_d = trial;
        q_d = {q_q[LEN_W-2:0], 1'b0};
      end
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q    <= '0;
      r_q    <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      dvs_q  <= '0;
    end else begin
      q_q    <= q_d;
      r_q    <= r_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      done_q <= done_d;
      dvs_q  <= dvs_d;
    end
  end

  assign done = done_q;
  assign quot = q_q;
  assign rem  = r_q[PART_W-1:0];

  AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (r_q < {1'b0, dvs_q})); // R3
  AST_DIV_NO_DONE_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !done_q); // R9
endmodule

// File: rtl/wpart_emit.sv
module wpart_emit #(
  parameter int LEN_W  = 16,
  parameter int PART_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [LEN_W-1:0]  quot,
  input  logic [PART_W-1:0] rem,
  input  logic [PART_W-1:0] parts,
  input  logic              step,
  output logic [PART_W-1:0] index,
  output logic [LEN_W-1:0]  count,
  output logic [LEN_W-1:0]  offset,
  output logic              last
);
  logic [PART_W-1:0] idx_q, idx_d;
  logic [LEN_W-1:0]  off_q, off_d;
  logic [LEN_W-1:0]  base_q, base_d;
  logic [PART_W-1:0] rem_q, rem_d;
  logic [PART_W-1:0] lastidx_q, lastidx_d;
  logic [LEN_W-1:0]  cur_cnt;

  assign cur_cnt = (idx_q < rem_q) ? base_q + 1'b1 : base_q;

  always_comb begin
    idx_d     = idx_q;
    off_d     = off_q;
    base_d    = base_q;
    rem_d     = rem_q;
    lastidx_d = lastidx_q;
    if (load) begin
      idx_d     = '0;
      off_d     = '0;
      base_d    = quot;
      rem_d     = rem;
      lastidx_d = parts - 1'b1;
    end else if (step) begin
      idx_d = idx_q + 1'b1;
      off_d = off_q + cur_cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q     <= '0;
      off_q     <= '0;
      base_q    <= '0;
      rem_q     <= '0;
      lastidx_q <= '0;
    end else begin
      idx_q     <= idx_d;
      off_q     <= off_d;
      base_q    <= base_d;
      rem_q     <= rem_d;
      lastidx_q <= lastidx_d;
    end
  end

  assign index  = idx_q;
  assign count  = cur_cnt;
  assign offset = off_q;
  assign last   = (idx_q == lastidx_q);

  AST_INDEX_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (idx_q == $past(idx_q) + 1'b1)); // R2
  AST_OFFSET_ACCUMULATES: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (off_q == $past(off_q) + $past(cur_cnt))); // R4
endmodule

// File: rtl/wpart_gen.sv
module wpart_gen #(
  parameter int MAX_PARTS = 16,
  parameter int LEN_W     = 16,
  localparam int PART_W   = $clog2(MAX_PARTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic [PART_W-1:0] cmd_parts,
  output logic              cmd_err,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PART_W-1:0] out_index,
  output logic [LEN_W-1:0]  out_count,
  output logic [LEN_W-1:0]  out_offset,
  output logic              out_last
);
  import wpart_pkg::*;

  wp_state_e st_q, st_d;
  logic [PART_W-1:0] parts_q, parts_d;
  logic              err_q, err_d;
  logic              accept, div_start, div_done, emit_load, emit_step;
  logic [LEN_W-1:0]  div_quot;
  logic [PART_W-1:0] div_rem;

  assign cmd_ready = (st_q == ST_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign div_start = accept && (cmd_parts != '0);
  assign emit_load = div_done;
  assign out_valid = (st_q == ST_EMIT);
  assign emit_step = out_valid && out_ready;
  assign cmd_err   = err_q;

  always_comb begin
    st_d    = st_q;
    parts_d = parts_q;
    err_d   = 1'b0;
    case (st_q)
      ST_IDLE: if (accept) begin
        parts_d = cmd_parts;
        if (cmd_parts == '0) begin
          st_d  = ST_ERR;
          err_d = 1'b1;
        end else begin
          st_d = ST_DIV;
        end
      end
      ST_DIV:  if (div_done) st_d = ST_EMIT;
      ST_EMIT: if (emit_step && out_last) st_d = ST_IDLE;
      ST_ERR:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      parts_q <= '0;
      err_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      parts_q <= parts_d;
      err_q   <= err_d;
    end
  end

  wpart_div #(.LEN_W(LEN_W), .PART_W(PART_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (div_start),
    .dividend (cmd_len),
    .divisor  (cmd_parts),
    .done     (div_done),
    .quot     (div_quot),
    .rem      (div_rem)
  );

  wpart_emit #(.LEN_W(LEN_W), .PART_W(PART_W)) u_emit (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (emit_load),
    .quot   (div_quot),
    .rem    (div_rem),
    .parts  (parts_q),
    .step   (emit_step),
    .index  (out_index),
    .count  (out_count),
    .offset (out_offset),
    .last   (out_last)
  );

  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_index) && $stable(out_count)
                                   && $stable(out_offset))); // R8
  AST_NO_READY_WHILE_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !cmd_ready); // R8
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |=> !cmd_err); // R7
  AST_ERR_NO_TUPLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> !out_valid); // R7
  AST_LAST_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last) |-> (out_index == parts_q - 1'b1)); // R5
  AST_INDEX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_index < parts_q)); // R2
endmodule

// File: tb/wpart_gen_test.sv
module wpart_gen_test;
  localparam int MP = 5;
  localparam int LW = 6;
  localparam int PW = $clog2(MP + 1);

  logic clk, rst_n;
  logic cmd_valid, cmd_ready, cmd_err;
  logic [LW-1:0] cmd_len;
  logic [PW-1:0] cmd_parts;
  logic out_valid, out_ready, out_last;
  logic [PW-1:0] out_index;
  logic [LW-1:0] out_count, out_offset;

  int n_chk = 0;
  int n_bad = 0;
  int lfsr = 32'h1ACE;
  bit stall_en = 0;

  wpart_gen #(.MAX_PARTS(MP), .LEN_W(LW)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_len(cmd_len), .cmd_parts(cmd_parts), .cmd_err(cmd_err),
    .out_valid(out_valid), .out_ready(out_ready), .out_index(out_index),
    .out_count(out_count), .out_offset(out_offset), .out_last(out_last)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic next_stall();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    out_ready = stall_en ? lfsr[0] | lfsr[3] : 1'b1;
  endtask

  task automatic run_cmd(input int L, input int N, input bit time_it);
    int q, r, off, got, lat, cnt_exp, guard;
    q = (N == 0) ? 0 : L / N;
    r = (N == 0) ? 0 : L % N;
    cmd_len = LW'(L);
    cmd_parts = PW'(N);
    cmd_valid = 1;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    #1 cmd_valid = 0;
    if (N == 0) begin
      @(negedge clk);
      chk(cmd_err == 1, "R7 err pulse", cmd_err, 1);
      chk(out_valid == 0, "R7 no tuple", out_valid, 0);
      @(negedge clk);
      chk(cmd_err == 0 && cmd_ready == 1, "R7 err single cycle", cmd_err, 0);
      return;
    end
    lat = 1;
    @(negedge clk);
    chk(cmd_ready == 0, "R8 locked during divide", cmd_ready, 0);
    while (!out_valid && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    if (time_it) chk(lat == LW + 2, "R9 first tuple latency", lat, LW + 2);
    got = 0;
    off = 0;
    guard = 0;
    while (got < N && guard < 1000) begin
      guard++;
      next_stall();
      if (out_valid) begin
        cnt_exp = (got < r) ? q + 1 : q;
        chk(out_index == PW'(got), "R2 index order", out_index, got);
        if (L < N && got >= L)
          chk(out_count == 0, "R6 zero-count tail", out_count, 0);
        else
          chk(out_count == LW'(cnt_exp), "R3 count", out_count, cnt_exp);
        chk(out_offset == LW'(off), "R4 offset", out_offset, off);
        chk(out_last == (got == N - 1), "R5 last flag", out_last, got == N - 1);
        chk(cmd_ready == 0, "R8 no command while streaming", cmd_ready, 0);
        if (out_ready) begin
          got++;
          off += cnt_exp;
        end
      end else begin
        chk(0, "R2 stream gap", 0, 1);
      end
      @(negedge clk);
    end
    out_ready = 1;
    chk(out_valid == 0, "R2 exactly N tuples", out_valid, 0);
    chk(cmd_ready == 1, "R8 ready after drain", cmd_ready, 1);
  endtask

  initial begin
    #400000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0;
    cmd_valid = 0;
    cmd_len = 0;
    cmd_parts = 0;
    out_ready = 1;
    repeat (3) @(negedge clk);
    chk(cmd_ready == 1, "R1 ready after reset", cmd_ready, 1);
    chk(out_valid == 0, "R1 no valid after reset", out_valid, 0);
    chk(cmd_err == 0, "R1 no err after reset", cmd_err, 0);
    rst_n = 1;
    @(negedge clk);
    run_cmd(37, 5, 1);
    for (int n = 0; n <= MP; n++)
      for (int l = 0; l < (1 << LW); l++)
        run_cmd(l, n, 0);
    stall_en = 1;
    for (int n = 1; n <= MP; n++)
      for (int l = 0; l < 20; l++)
        run_cmd(l * 3, n, 0);
    run_cmd(63, 0, 0);
    run_cmd(2, 4, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule